// File: doc/BRIEF.md
# Excess-3 Decimal Adder

This block adds two unsigned decimal numbers of `NDIG` digits. Each digit is held in excess-3 code, four bits per digit. The sum comes back in the same code, together with a decimal carry out. Inside each digit cell the two code words and the incoming carry are added in binary. The cell then corrects the result back into excess-3. If no decimal carry arises it takes 3 away; if one arises it adds 3 and passes the carry to the next cell. The decimal carry ripples from the least significant digit upward.

A mode input turns the same datapath into a subtractor. The code is self-complementing, so inverting every bit of the second operand gives its nine's complement. Forcing the incoming carry to one then gives ten's-complement subtraction. Results are captured only on a start strobe. A one-cycle valid pulse marks each new result, and the registered outputs hold their values until the next strobe. A per-digit error vector reports operand digits that are not legal excess-3 codes.

Top module: `xs3_dec_adder`

## Requirements
- R1: A decimal digit d is carried as the 4-bit value d+3 (0 is 0011, 9 is 1100). Digit i of each operand and of the sum sits at bits [4i+3:4i], and digit 0 is the least significant.
- R2: With mode_sub=0, the registered sum is (A + B + carry_in) mod 10^NDIG, encoded per R1. carry_out is 1 exactly when A + B + carry_in is 10^NDIG or more.
- R3: Each digit cell subtracts 3 from its binary sum when that digit's decimal total is below 10. Otherwise it adds 3 and sends a carry into the next digit, so a carry can ripple through every digit (for example 99 + 0 + 1 gives 00 with carry_out 1).
- R4: With mode_sub=1, every bit of B is inverted and the incoming carry is forced to 1, whatever carry_in holds. The sum is (A − B) mod 10^NDIG, and carry_out is 1 exactly when A ≥ B.
- R5: Sum, carry_out and digit_err are loaded on the clock edge at which start is sampled high. valid is high for exactly the cycle after each such edge and low otherwise.
- R6: While start is low, sum, carry_out and digit_err keep their values whatever the operand and mode inputs do.
- R7: digit_err bit i is loaded with 1 when digit i of A or of the raw B input lies outside 0011..1100. The sum digits are then undefined.
- R8: A synchronous active-low reset clears sum, carry_out, digit_err and valid to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Capture strobe for a new result |
| mode_sub | input | 1 | 0 adds, 1 subtracts B from A |
| carry_in | input | 1 | Decimal carry into digit 0 in add mode |
| opnd_a | input | 4*NDIG | First operand, excess-3 digits |
| opnd_b | input | 4*NDIG | Second operand, excess-3 digits |
| sum | output | 4*NDIG | Registered result, excess-3 digits |
| carry_out | output | 1 | Registered decimal carry out of the top digit |
| valid | output | 1 | One-cycle pulse after a capture |
| digit_err | output | NDIG | Registered per-digit illegal-code flags |

## Verification
The assertion on the range of the sum digits assumes both operands carry only legal excess-3 codes whenever start is high. It is therefore gated by a clear digit_err, since illegal codes make the result undefined. The exhaustive sweep stays inside that assumption by building every operand from integers 0 to 99 through the encoding of R1. The illegal codes appear only in separate vectors, where just the error flags are checked. The hold and pulse properties assume nothing about the operands, so the bench changes the operands freely while start is low.

// File: rtl/xs3_pkg.sv
// Shared constants and helpers for the excess-3 decimal adder.
// Assumes four bits per digit; legal codes are 3 to 12 inclusive.
package xs3_pkg;
    localparam int unsigned DIG_W   = 4;
    localparam logic [3:0]  XS3_LO  = 4'd3;
    localparam logic [3:0]  XS3_HI  = 4'd12;
    localparam logic [3:0]  XS3_ADJ = 4'd3;

    // True when a 4-bit code is a legal excess-3 digit.
    function automatic logic xs3_legal(input logic [3:0] code);
        return (code >= XS3_LO) && (code <= XS3_HI);
    endfunction
endpackage

// File: rtl/xs3_operand_prep.sv
// Conditions the second operand and the initial carry for add or subtract.
// In subtract mode every bit of B is inverted (nine's complement, since the
// code is self-complementing) and the carry into digit 0 is forced to 1.
module xs3_operand_prep #(
    parameter int unsigned OPW = 8
) (
    input  logic           mode_sub,
    input  logic           carry_in,
    input  logic [OPW-1:0] b_raw,
    output logic [OPW-1:0] b_eff,
    output logic           carry_first
);
    // Select between true and complemented B, and the matching first carry.
    always_comb begin
        if (mode_sub) begin
            b_eff       = ~b_raw;
            carry_first = 1'b1;
        end else begin
            b_eff       = b_raw;
            carry_first = carry_in;
        end
    end
endmodule

// File: rtl/xs3_digit_screen.sv
// Flags every digit position where either operand holds an illegal code.
// Operates on the raw inputs, before any complementing.
module xs3_digit_screen
    import xs3_pkg::*;
#(
    parameter int unsigned NDIG = 2
) (
    input  logic [NDIG*DIG_W-1:0] a_raw,
    input  logic [NDIG*DIG_W-1:0] b_raw,
    output logic [NDIG-1:0]       bad
);
    for (genvar gi = 0; gi < NDIG; gi++) begin : g_scr
        // One comparator pair per digit position.
        always_comb begin
            bad[gi] = !xs3_legal(a_raw[gi*DIG_W +: DIG_W])
                   || !xs3_legal(b_raw[gi*DIG_W +: DIG_W]);
        end
    end
endmodule

// File: rtl/xs3_digit_cell.sv
// One excess-3 digit adder: binary add of two codes plus carry, then
// correction. Carry out of bit 3 marks a decimal total of ten or more;
// the cell then adds 3, otherwise it subtracts 3.
// Assumes legal input codes; the result is undefined otherwise.
module xs3_digit_cell
    import xs3_pkg::*;
(
    input  logic [DIG_W-1:0] dig_a,
    input  logic [DIG_W-1:0] dig_b,
    input  logic             c_in,
    output logic [DIG_W-1:0] dig_s,
    output logic             c_out
);
    logic [DIG_W:0] raw;

    // Binary sum of the two codes and the incoming decimal carry.
    always_comb begin
        raw = {1'b0, dig_a} + {1'b0, dig_b} + {{DIG_W{1'b0}}, c_in};
    end

    // Excess-3 correction driven by the binary carry.
    always_comb begin
        c_out = raw[DIG_W];
        if (raw[DIG_W]) dig_s = raw[DIG_W-1:0] + XS3_ADJ;
        else            dig_s = raw[DIG_W-1:0] - XS3_ADJ;
    end
endmodule

// File: rtl/xs3_dec_adder.sv
// Multi-digit excess-3 adder/subtractor with a registered result stage.
// A ripple chain of digit cells forms the result combinationally; it is
// captured when start is high, and valid pulses for one cycle afterwards.
// Assumes start is only raised with legal operand codes when a defined sum
// is wanted; digit_err reports the positions that broke this.
module xs3_dec_adder
    import xs3_pkg::*;
#(
    parameter int unsigned NDIG = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  mode_sub,
    input  logic                  carry_in,
    input  logic [NDIG*DIG_W-1:0] opnd_a,
    input  logic [NDIG*DIG_W-1:0] opnd_b,
    output logic [NDIG*DIG_W-1:0] sum,
    output logic                  carry_out,
    output logic                  valid,
    output logic [NDIG-1:0]       digit_err
);
    localparam int unsigned OPW = NDIG * DIG_W;

    logic [OPW-1:0]  b_eff;
    logic [NDIG:0]   chain;
    logic [OPW-1:0]  sum_c;
    logic [NDIG-1:0] bad_c;

    logic [OPW-1:0]  sum_q;
    logic            cy_q;
    logic            vld_q;
    logic [NDIG-1:0] err_q;

    xs3_operand_prep #(.OPW(OPW)) u_prep (
        .mode_sub    (mode_sub),
        .carry_in    (carry_in),
        .b_raw       (opnd_b),
        .b_eff       (b_eff),
        .carry_first (chain[0])
    );

    xs3_digit_screen #(.NDIG(NDIG)) u_screen (
        .a_raw (opnd_a),
        .b_raw (opnd_b),
        .bad   (bad_c)
    );

    for (genvar gd = 0; gd < NDIG; gd++) begin : g_dig
        xs3_digit_cell u_cell (
            .dig_a (opnd_a[gd*DIG_W +: DIG_W]),
            .dig_b (b_eff[gd*DIG_W +: DIG_W]),
            .c_in  (chain[gd]),
            .dig_s (sum_c[gd*DIG_W +: DIG_W]),
            .c_out (chain[gd+1])
        );
    end

    // Result stage: load on start, pulse valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            cy_q  <= 1'b0;
            vld_q <= 1'b0;
            err_q <= '0;
        end else begin
            vld_q <= start;
            if (start) begin
                sum_q <= sum_c;
                cy_q  <= chain[NDIG];
                err_q <= bad_c;
            end
        end
    end

    assign sum       = sum_q;
    assign carry_out = cy_q;
    assign valid     = vld_q;
    assign digit_err = err_q;

    // R5: a strobe yields a valid pulse on the next cycle.
    a_r5_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);
    // R5: no strobe, no valid.
    a_r5_valid_only_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !valid);
    // R6: registered outputs stay put while start is low.
    a_r6_hold_without_start: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(sum) && $stable(carry_out) && $stable(digit_err)));
    // R7: legal operands at the strobe leave no error flag.
    a_r7_no_flag_on_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (bad_c == '0)) |=> (digit_err == '0));

    for (genvar gk = 0; gk < NDIG; gk++) begin : g_chk
        // R1, R3: a result built from legal digits is itself legal excess-3.
        a_r3_sum_digit_legal: assert property (@(posedge clk) disable iff (!rst_n)
            (valid && (digit_err == '0)) |-> xs3_legal(sum[gk*DIG_W +: DIG_W]));
    end
endmodule

// File: tb/xs3_dec_adder_tb.sv
module xs3_dec_adder_tb;
    localparam int ND   = 2;
    localparam int W    = 4 * ND;
    localparam int MODV = 100;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic          mode_sub;
    logic          carry_in;
    logic [W-1:0]  opnd_a;
    logic [W-1:0]  opnd_b;
    logic [W-1:0]  sum;
    logic          carry_out;
    logic          valid;
    logic [ND-1:0] digit_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    xs3_dec_adder #(.NDIG(ND)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_sub(mode_sub),
        .carry_in(carry_in), .opnd_a(opnd_a), .opnd_b(opnd_b), .sum(sum),
        .carry_out(carry_out), .valid(valid), .digit_err(digit_err)
    );

    function automatic logic [W-1:0] enc(input int v);
        logic [W-1:0] r = '0;
        int t = v;
        for (int i = 0; i < ND; i++) begin
            r[4*i +: 4] = 4'((t % 10) + 3);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply one operation with a single-cycle strobe, then check the result.
    task automatic run(input int a, input int b, input logic ci,
                       input logic sm, input string req);
        int t;
        @(negedge clk);
        opnd_a = enc(a); opnd_b = enc(b); carry_in = ci; mode_sub = sm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = sm ? (a + (MODV - 1 - b) + 1) : (a + b + int'(ci));
        check(req, "sum",   32'(sum),       32'(enc(t % MODV)));
        check(req, "carry", 32'(carry_out), 32'(t >= MODV));
        check("R5", "valid", 32'(valid),    32'd1);
        check("R7", "err",  32'(digit_err), 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; mode_sub = 1'b0; carry_in = 1'b0;
        opnd_a = '0; opnd_b = '0;
        repeat (5) @(negedge clk);
        // R8: reset state
        check("R8", "sum",   32'(sum),       32'd0);
        check("R8", "carry", 32'(carry_out), 32'd0);
        check("R8", "valid", 32'(valid),     32'd0);
        check("R8", "err",   32'(digit_err), 32'd0);
        rst_n = 1'b1;

        // R1: digits encoded as value+3, digit 0 least significant (12+15 = 27 -> 0101 1010)
        run(12, 15, 1'b0, 1'b0, "R1");
        check("R1", "code", 32'(sum), 32'h5A);

        // R3: ripple through every digit, and add-3 / sub-3 corrections
        run(99, 0, 1'b1, 1'b0, "R3");
        check("R3", "ripple", 32'(sum), 32'h33);
        run(9, 1, 1'b0, 1'b0, "R3");
        run(4, 5, 1'b0, 1'b0, "R3");

        // R5: valid drops the cycle after the pulse
        @(negedge clk);
        check("R5", "valid low", 32'(valid), 32'd0);

        // R6: inputs change with start low; outputs hold
        run(37, 48, 1'b0, 1'b0, "R6");
        @(negedge clk);
        opnd_a = enc(91); opnd_b = enc(88); carry_in = 1'b1; mode_sub = 1'b1;
        @(negedge clk);
        check("R6", "sum held",   32'(sum),       32'(enc(85)));
        check("R6", "carry held", 32'(carry_out), 32'd0);
        check("R6", "valid",      32'(valid),     32'd0);

        // R7: illegal digit in A position 0, then in B position 1 (subtract mode)
        @(negedge clk);
        opnd_a = 8'hCF; opnd_b = enc(5); mode_sub = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7", "err a0", 32'(digit_err), 32'h1);
        @(negedge clk);
        opnd_a = enc(40); opnd_b = 8'h04; mode_sub = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7", "err b1", 32'(digit_err), 32'h2);

        // R2 and R4: exhaustive sweep over two digits
        for (int a = 0; a < MODV; a++)
            for (int b = 0; b < MODV; b++)
                for (int c = 0; c < 2; c++) begin
                    run(a, b, logic'(c), 1'b0, "R2");
                    run(a, b, logic'(c), 1'b1, "R4");
                end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule